// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block turns the two-step configuration access used on a host I/O-port bus into single requests toward a configuration target. First, software writes a 32-bit selector to the address port at 0xCF8. The selector holds an enable bit and the bus, device, function and dword register of the target. Software then reads or writes a byte, word or dword through the four-byte data window at 0xCFC–0xCFF. Each such window access becomes one 32-bit configuration transaction. The transaction carries byte enables chosen by the port offset and the access size.

Write data from the host sits at bit 0 and is moved onto the selected byte lanes. Read data from the target is moved back down to bit 0 and zero-extended. When the selector is disabled, the window produces no traffic. A target error, and any port outside the eight decoded ones, both read as all ones. Only the first 256 bytes of a function's configuration space can be reached: 64 dwords through a 6-bit register index.

The host issues one access at a time. It pulses `io_req` while `io_busy` is low, then waits for the one-cycle `io_done` pulse that carries `io_rdata`.

Top module: `cfgport_bridge`

## Requirements
- R1: After synchronous reset, `io_busy`, `io_done` and `cfg_valid` are low and the stored selector is zero.
- R2: A dword write (`io_size` 2 or 3) to port 0xCF8 stores the selector. A later dword read of 0xCF8 returns it with bits 30:24 and 1:0 forced to zero. Bit 31 is the enable, bits 23:16 the bus, 15:11 the device, 10:8 the function and 7:2 the dword index.
- R3: Byte (`io_size` 0) and word (`io_size` 1) accesses to 0xCF8–0xCFB leave the selector unchanged, and their reads return zero.
- R4: With selector bit 31 set, each access to 0xCFC–0xCFF issues exactly one request. The request's bus, device, function and register fields equal the selector fields, and `cfg_we` equals `io_wr`.
- R5: The byte enables follow the access. A byte access at offset k (the port's low two bits) sets only enable bit k. A word access sets bits 1:0 when port bit 1 is 0 and bits 3:2 when it is 1; port bit 0 is ignored. A dword access sets all four bits.
- R6: On a write, host data bits starting at bit 0 appear on the enabled lanes of `cfg_wdata`.
- R7: On a read, the enabled lanes of `cfg_rdata` are returned starting at bit 0 of `io_rdata`, and the upper bits are zero.
- R8: With selector bit 31 clear, window accesses issue no request, reads return 32'hFFFFFFFF and writes change nothing.
- R9: A response with `cfg_rsp_err` high returns 32'hFFFFFFFF to the host.
- R10: While `cfg_valid` is high and `cfg_ready` low, the request and all of its fields stay unchanged on the next cycle.
- R11: An access that issues no request raises `io_done` in the cycle after `io_req`. A request completes with `io_done` in the cycle after `cfg_rsp_valid`. `io_busy` is low whenever `io_done` is high.
- R12: An access to any port outside 0xCF8–0xCFF issues no request, leaves the selector unchanged and reads 32'hFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | One-cycle host access pulse, taken only when not busy |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| io_wdata | input | 32 | Host write data, aligned to bit 0 |
| io_busy | output | 1 | Access in progress |
| io_done | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Read data, valid with `io_done` |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_ready | input | 1 | Target accepts the request |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_func | output | 3 | Target function number |
| cfg_reg | output | 6 | Dword register index |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-steered write data |
| cfg_rsp_valid | input | 1 | Response valid, in a cycle after acceptance |
| cfg_rsp_err | input | 1 | Error or no device |
| cfg_rdata | input | 32 | Read data from target |

## Verification
Several properties hold on every cycle and are checked that way: the request stays stable while stalled, it carries the selector fields when it starts, its enable count is one, two or four lanes, a disabled window never starts a request, an error response becomes all ones, and completion comes one cycle after a local access. Only the bench scenarios can show the data path. That covers lane placement of write data, downward alignment and zero extension of reads, the reserved-bit masking of the stored selector, and the fact that narrow selector writes and undecoded ports leave the selector untouched. These scenarios compare values against a target model whose contents change only through the requests it accepts.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int CFG_DW  = 32;
  localparam int CFG_NB  = CFG_DW / 8;
  localparam int LANE_W  = $clog2(CFG_NB);
  localparam int IO_AW   = 16;
  localparam int BUS_W   = 8;
  localparam int DEV_W   = 5;
  localparam int FN_W    = 3;
  localparam int REG_W   = 6;
  // selector bits kept by the latch (bits 23:2)
  localparam int SEL_W   = BUS_W + DEV_W + FN_W + REG_W;

  typedef enum logic [1:0] {CLS_MISS, CLS_ADDR, CLS_DATA} port_cls_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} br_state_e;
endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
  import cfgport_pkg::*;
#(
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC
) (
  input  logic [IO_AW-1:0]  addr,
  input  logic [1:0]        size,
  input  logic [CFG_DW-1:0] wdata,
  output port_cls_e         cls,
  output logic [LANE_W-1:0] lane,
  output logic [CFG_NB-1:0] be,
  output logic [CFG_DW-1:0] wdata_lanes
);
  always_comb begin
    if (addr[IO_AW-1:LANE_W] == ADDR_PORT[IO_AW-1:LANE_W])      cls = CLS_ADDR;
    else if (addr[IO_AW-1:LANE_W] == DATA_PORT[IO_AW-1:LANE_W]) cls = CLS_DATA;
    else                                                        cls = CLS_MISS;
  end

  always_comb begin
    if (size == 2'd0) begin
      lane = addr[LANE_W-1:0];
      be   = CFG_NB'(1) << lane;
    end else if (size == 2'd1) begin
      lane = {addr[LANE_W-1:1], 1'b0};
      be   = CFG_NB'(3) << lane;
    end else begin
      lane = '0;
      be   = '1;
    end
    wdata_lanes = wdata << {lane, 3'b000};
  end
endmodule

// File: rtl/cfgport_addr_latch.sv
module cfgport_addr_latch
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              din_en,
  input  logic [SEL_W-1:0]  din_sel,
  output logic [CFG_DW-1:0] q
);
  localparam int RSVD_W = CFG_DW - 1 - SEL_W - 2;

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= {din_en, {RSVD_W{1'b0}}, din_sel, 2'b00};
  end
endmodule

// File: rtl/cfgport_rd_align.sv
module cfgport_rd_align
  import cfgport_pkg::*;
(
  input  logic [CFG_DW-1:0] rdata,
  input  logic              err,
  input  logic [LANE_W-1:0] lane,
  input  logic [1:0]        size,
  output logic [CFG_DW-1:0] aligned
);
  logic [CFG_DW-1:0] shifted;

  always_comb begin
    shifted = rdata >> {lane, 3'b000};
    if (err)                aligned = '1;
    else if (size == 2'd0)  aligned = CFG_DW'(shifted[7:0]);
    else if (size == 2'd1)  aligned = CFG_DW'(shifted[15:0]);
    else                    aligned = shifted;
  end
endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
  import cfgport_pkg::*;
#(
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req,
  input  logic              io_wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [1:0]        io_size,
  input  logic [CFG_DW-1:0] io_wdata,
  output logic              io_busy,
  output logic              io_done,
  output logic [CFG_DW-1:0] io_rdata,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic              cfg_we,
  output logic [BUS_W-1:0]  cfg_bus,
  output logic [DEV_W-1:0]  cfg_dev,
  output logic [FN_W-1:0]   cfg_func,
  output logic [REG_W-1:0]  cfg_reg,
  output logic [CFG_NB-1:0] cfg_be,
  output logic [CFG_DW-1:0] cfg_wdata,
  input  logic              cfg_rsp_valid,
  input  logic              cfg_rsp_err,
  input  logic [CFG_DW-1:0] cfg_rdata
);
  localparam int REG_LO = 2;
  localparam int FN_LO  = REG_LO + REG_W;
  localparam int DEV_LO = FN_LO + FN_W;
  localparam int BUS_LO = DEV_LO + DEV_W;

  br_state_e         state;
  port_cls_e         cls;
  logic [LANE_W-1:0] lane, lane_q;
  logic [1:0]        size_q;
  logic [CFG_NB-1:0] be;
  logic [CFG_DW-1:0] wdata_lanes;
  logic [CFG_DW-1:0] latch_q;
  logic [CFG_DW-1:0] aligned;
  logic              accept, latch_we;

  assign accept   = io_req && (state == ST_IDLE);
  assign latch_we = accept && (cls == CLS_ADDR) && io_wr && io_size[1];
  assign io_busy  = (state != ST_IDLE);

  cfgport_decode #(.ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_decode (
    .addr(io_addr), .size(io_size), .wdata(io_wdata),
    .cls(cls), .lane(lane), .be(be), .wdata_lanes(wdata_lanes)
  );

  cfgport_addr_latch u_latch (
    .clk(clk), .rst(rst), .we(latch_we),
    .din_en(io_wdata[CFG_DW-1]), .din_sel(io_wdata[SEL_W+1:2]),
    .q(latch_q)
  );

  cfgport_rd_align u_align (
    .rdata(cfg_rdata), .err(cfg_rsp_err), .lane(lane_q), .size(size_q),
    .aligned(aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      io_done   <= 1'b0;
      io_rdata  <= '0;
      cfg_valid <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_bus   <= '0;
      cfg_dev   <= '0;
      cfg_func  <= '0;
      cfg_reg   <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
      lane_q    <= '0;
      size_q    <= '0;
    end else begin
      io_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            case (cls)
              CLS_ADDR: begin
                io_rdata <= (!io_wr && io_size[1]) ? latch_q : '0;
                io_done  <= 1'b1;
              end
              CLS_DATA: begin
                if (latch_q[CFG_DW-1]) begin
                  cfg_valid <= 1'b1;
                  cfg_we    <= io_wr;
                  cfg_bus   <= latch_q[BUS_LO +: BUS_W];
                  cfg_dev   <= latch_q[DEV_LO +: DEV_W];
                  cfg_func  <= latch_q[FN_LO +: FN_W];
                  cfg_reg   <= latch_q[REG_LO +: REG_W];
                  cfg_be    <= be;
                  cfg_wdata <= wdata_lanes;
                  lane_q    <= lane;
                  size_q    <= io_size;
                  state     <= ST_REQ;
                end else begin
                  io_rdata <= '1;
                  io_done  <= 1'b1;
                end
              end
              default: begin
                io_rdata <= '1;
                io_done  <= 1'b1;
              end
            endcase
          end
        end
        ST_REQ: begin
          if (cfg_ready) begin
            cfg_valid <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cfg_rsp_valid) begin
            io_rdata <= aligned;
            io_done  <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgport_bridge_chk.sv
module cfgport_bridge_chk
  import cfgport_pkg::*;
#(
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC
) (
  input logic              clk,
  input logic              rst,
  input logic              io_req,
  input logic [IO_AW-1:0]  io_addr,
  input logic              io_busy,
  input logic              io_done,
  input logic [CFG_DW-1:0] io_rdata,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic              cfg_we,
  input logic [BUS_W-1:0]  cfg_bus,
  input logic [DEV_W-1:0]  cfg_dev,
  input logic [FN_W-1:0]   cfg_func,
  input logic [REG_W-1:0]  cfg_reg,
  input logic [CFG_NB-1:0] cfg_be,
  input logic [CFG_DW-1:0] cfg_wdata,
  input logic              cfg_rsp_valid,
  input logic              cfg_rsp_err,
  input logic [CFG_DW-1:0] latch_q
);
  logic hit_addr, hit_data;
  assign hit_addr = io_addr[IO_AW-1:LANE_W] == ADDR_PORT[IO_AW-1:LANE_W];
  assign hit_data = io_addr[IO_AW-1:LANE_W] == DATA_PORT[IO_AW-1:LANE_W];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_we) && $stable(cfg_bus) &&
      $stable(cfg_dev) && $stable(cfg_func) && $stable(cfg_reg) && $stable(cfg_be) &&
      $stable(cfg_wdata))); // R10

  AST_REQ_FIELDS: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_valid) |-> (cfg_bus == latch_q[23:16] && cfg_dev == latch_q[15:11] &&
      cfg_func == latch_q[10:8] && cfg_reg == latch_q[7:2])); // R4

  AST_BE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> ($countones(cfg_be) == 1 || cfg_be == 4'b0011 || cfg_be == 4'b1100 ||
      cfg_be == 4'b1111)); // R5

  AST_DISABLED_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (io_req && !io_busy && hit_data && !latch_q[CFG_DW-1]) |=>
      (!cfg_valid && io_done && io_rdata == '1)); // R8

  AST_ERR_ONES: assert property (@(posedge clk) disable iff (rst)
    (io_busy && !cfg_valid && cfg_rsp_valid && cfg_rsp_err) |=>
      (io_done && io_rdata == '1)); // R9

  AST_LOCAL_DONE: assert property (@(posedge clk) disable iff (rst)
    (io_req && !io_busy && hit_addr) |=> (io_done && !cfg_valid)); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    io_done |-> !io_busy); // R11

  AST_MISS_ONES: assert property (@(posedge clk) disable iff (rst)
    (io_req && !io_busy && !hit_addr && !hit_data) |=>
      (io_done && io_rdata == '1 && !cfg_valid)); // R12
endmodule

bind cfgport_bridge cfgport_bridge_chk #(.ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_chk (
  .clk(clk), .rst(rst), .io_req(io_req), .io_addr(io_addr), .io_busy(io_busy),
  .io_done(io_done), .io_rdata(io_rdata), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_func(cfg_func),
  .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
  .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_err(cfg_rsp_err), .latch_q(latch_q)
);

// File: tb/test_cfgport_bridge.sv
module test_cfgport_bridge;
  logic        clk = 1'b0;
  logic        rst;
  logic        io_req, io_wr;
  logic [15:0] io_addr;
  logic [1:0]  io_size;
  logic [31:0] io_wdata;
  logic        io_busy, io_done;
  logic [31:0] io_rdata;
  logic        cfg_valid, cfg_ready, cfg_we;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_rsp_valid, cfg_rsp_err;
  logic [31:0] cfg_rdata;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  cfgport_bridge i_cfgport_bridge (
    .clk(clk), .rst(rst), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
    .io_size(io_size), .io_wdata(io_wdata), .io_busy(io_busy), .io_done(io_done),
    .io_rdata(io_rdata), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_we(cfg_we),
    .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_func(cfg_func), .cfg_reg(cfg_reg),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rsp_valid(cfg_rsp_valid),
    .cfg_rsp_err(cfg_rsp_err), .cfg_rdata(cfg_rdata)
  );

  // ---------------- target model ----------------
  logic [31:0] tmem [64];
  int          req_cnt = 0;
  logic        last_we;
  logic [7:0]  last_bus;
  logic [4:0]  last_dev;
  logic [2:0]  last_func;
  logic [5:0]  last_reg;
  logic [3:0]  last_be;
  logic [31:0] last_wdata;

  initial begin
    int          tstate, tdelay, rdelay;
    logic        terr;
    logic [31:0] tdata;
    for (int k = 0; k < 64; k++) tmem[k] = 32'hA5000000 | k;
    cfg_ready = 0; cfg_rsp_valid = 0; cfg_rsp_err = 0; cfg_rdata = 0;
    tstate = 0; tdelay = 0; rdelay = 0; terr = 0; tdata = 0;
    forever begin
      @(negedge clk);
      cfg_ready = 0; cfg_rsp_valid = 0; cfg_rsp_err = 0;
      if (tstate == 0) begin
        if (cfg_valid) begin
          if (tdelay == 0) begin
            cfg_ready = 1;
            req_cnt++;
            last_we = cfg_we; last_bus = cfg_bus; last_dev = cfg_dev;
            last_func = cfg_func; last_reg = cfg_reg; last_be = cfg_be;
            last_wdata = cfg_wdata;
            terr = (cfg_bus == 8'hEE);
            if (cfg_we && !terr)
              for (int b = 0; b < 4; b++)
                if (cfg_be[b]) tmem[cfg_reg][b*8 +: 8] = cfg_wdata[b*8 +: 8];
            tdata  = tmem[cfg_reg];
            rdelay = $urandom % 3;
            tstate = 1;
          end else tdelay--;
        end
      end else begin
        if (rdelay == 0) begin
          cfg_rsp_valid = 1;
          cfg_rsp_err   = terr;
          cfg_rdata     = terr ? $urandom : tdata;
          tstate = 0;
          tdelay = $urandom % 3;
        end else rdelay--;
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [1:0] exp_lane(logic [15:0] a, logic [1:0] sz);
    if (sz == 2'd0) return a[1:0];
    if (sz == 2'd1) return {a[1], 1'b0};
    return 2'd0;
  endfunction

  function automatic logic [3:0] exp_be(logic [15:0] a, logic [1:0] sz);
    if (sz == 2'd0) return 4'b0001 << exp_lane(a, sz);
    if (sz == 2'd1) return 4'b0011 << exp_lane(a, sz);
    return 4'b1111;
  endfunction

  function automatic logic [31:0] be_mask(logic [3:0] be);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [31:0] exp_read(logic [31:0] w, logic [15:0] a, logic [1:0] sz);
    logic [31:0] s = w >> (8 * exp_lane(a, sz));
    if (sz == 2'd0) return {24'h0, s[7:0]};
    if (sz == 2'd1) return {16'h0, s[15:0]};
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_access(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                           input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    io_req = 1; io_wr = wr; io_addr = a; io_size = sz; io_wdata = wd;
    @(negedge clk);
    io_req = 0;
    lat = 1;
    while (!io_done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    rd = io_rdata;
  endtask

  logic [31:0] exp_latch = '0;

  task automatic set_latch(input logic [31:0] v);
    logic [31:0] rd; int lat;
    io_access(1, 16'hCF8, 2'd2, v, rd, lat);
    exp_latch = v & 32'h80FF_FFFC;
  endtask

  // data-window access with full checking against the target model
  task automatic win_access(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                            input logic [31:0] wd);
    logic [31:0] rd, pre_word, expv, m;
    int lat, pre_cnt;
    bit en, err;
    en = exp_latch[31];
    err = (exp_latch[23:16] == 8'hEE);
    pre_cnt = req_cnt;
    pre_word = tmem[exp_latch[7:2]];
    io_access(wr, a, sz, wd, rd, lat);
    if (en) begin
      chk(req_cnt == pre_cnt + 1, "R4 one request", req_cnt, pre_cnt + 1);
      chk({last_bus, last_dev, last_func, last_reg} == exp_latch[23:2], "R4 fields",
          {8'h0, last_bus, last_dev, last_func, last_reg}, {8'h0, exp_latch[23:2]});
      chk(last_we == wr, "R4 we", last_we, wr);
      chk(last_be == exp_be(a, sz), "R5 be", last_be, exp_be(a, sz));
      if (wr) begin
        m = be_mask(exp_be(a, sz));
        chk((last_wdata & m) == ((wd << (8 * exp_lane(a, sz))) & m), "R6 wdata lanes",
            last_wdata & m, (wd << (8 * exp_lane(a, sz))) & m);
      end else begin
        expv = err ? 32'hFFFF_FFFF : exp_read(tmem[exp_latch[7:2]], a, sz);
        if (err) chk(rd == expv, "R9 error read", rd, expv);
        else     chk(rd == expv, "R7 read align", rd, expv);
      end
    end else begin
      chk(req_cnt == pre_cnt, "R8 no request", req_cnt, pre_cnt);
      chk(tmem[exp_latch[7:2]] == pre_word, "R8 no change", tmem[exp_latch[7:2]], pre_word);
      chk(lat == 1, "R11 local latency", lat, 1);
      if (!wr) chk(rd == 32'hFFFF_FFFF, "R8 ones", rd, 32'hFFFF_FFFF);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [31:0] rd;
    int lat, pre;
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst = 1; io_req = 0; io_wr = 0; io_addr = 0; io_size = 0; io_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!io_busy && !io_done && !cfg_valid, "R1 reset outputs",
        {29'h0, io_busy, io_done, cfg_valid}, 0);
    rst = 0;
    io_access(0, 16'hCF8, 2'd2, 0, rd, lat);
    chk(rd == 0, "R1 selector zero", rd, 0);

    // R2 reserved bits masked
    io_access(1, 16'hCF8, 2'd3, 32'hFFFF_FFFF, rd, lat);
    chk(lat == 1, "R11 local latency", lat, 1);
    io_access(0, 16'hCF8, 2'd2, 0, rd, lat);
    chk(rd == 32'h80FF_FFFC, "R2 readback", rd, 32'h80FF_FFFC);

    // R3 narrow selector accesses
    io_access(1, 16'hCF8, 2'd0, 32'h0, rd, lat);
    io_access(1, 16'hCFA, 2'd1, 32'h0, rd, lat);
    io_access(0, 16'hCF8, 2'd2, 0, rd, lat);
    chk(rd == 32'h80FF_FFFC, "R3 narrow write ignored", rd, 32'h80FF_FFFC);
    io_access(0, 16'hCF9, 2'd0, 0, rd, lat);
    chk(rd == 0, "R3 byte read zero", rd, 0);
    io_access(0, 16'hCFA, 2'd1, 0, rd, lat);
    chk(rd == 0, "R3 word read zero", rd, 0);

    // directed window accesses: bus 3, dev 5, func 2, reg 9
    set_latch(32'h8000_0000 | (3 << 16) | (5 << 11) | (2 << 8) | (9 << 2));
    win_access(1, 16'hCFC, 2'd2, 32'h1122_3344);
    win_access(1, 16'hCFE, 2'd0, 32'hFFFF_FFAB);
    chk(tmem[9] == 32'h11AB_3344, "R6 byte merge", tmem[9], 32'h11AB_3344);
    win_access(0, 16'hCFE, 2'd0, 0);
    win_access(0, 16'hCFD, 2'd1, 0);
    win_access(0, 16'hCFE, 2'd1, 0);
    win_access(0, 16'hCFF, 2'd0, 0);
    win_access(0, 16'hCFC, 2'd2, 0);
    win_access(1, 16'hCFF, 2'd1, 32'h0000_BEEF);

    // R8 disabled window
    set_latch(32'h0003_2A24);
    win_access(1, 16'hCFC, 2'd2, 32'hDEAD_DEAD);
    win_access(0, 16'hCFD, 2'd0, 0);

    // R9 error target
    set_latch(32'h80EE_0010);
    win_access(0, 16'hCFC, 2'd2, 0);
    win_access(0, 16'hCFE, 2'd1, 0);

    // R12 undecoded port
    pre = req_cnt;
    io_access(1, 16'h0CF4, 2'd2, 32'h1234_5678, rd, lat);
    io_access(0, 16'h0080, 2'd2, 0, rd, lat);
    chk(rd == 32'hFFFF_FFFF, "R12 miss reads ones", rd, 32'hFFFF_FFFF);
    chk(lat == 1, "R11 miss latency", lat, 1);
    chk(req_cnt == pre, "R12 no request", req_cnt, pre);
    io_access(0, 16'hCF8, 2'd2, 0, rd, lat);
    chk(rd == exp_latch, "R12 selector kept", rd, exp_latch);

    // constrained random
    for (int i = 0; i < 200; i++) begin
      if (i % 4 == 0) begin
        logic [31:0] v;
        v = $urandom;
        v[31] = ($urandom % 8) != 0;
        if ($urandom % 6 == 0) v[23:16] = 8'hEE;
        else if (v[23:16] == 8'hEE) v[23:16] = 8'h01;
        set_latch(v);
        io_access(0, 16'hCF8, 2'd2, 0, rd, lat);
        chk(rd == exp_latch, "R2 random readback", rd, exp_latch);
      end
      win_access($urandom % 2, 16'hCFC + 16'($urandom % 4), 2'($urandom % 4), $urandom);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule